// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block produces one rectangular waveform from a down-counter. After a start, the counter is loaded with a period value. It then steps down to zero on each count tick and reloads on the tick after zero. The output is in its active phase while the count is above a duty value, and in its inactive phase otherwise. The count tick comes from a small prescaler that divides the machine clock by a power of two. It can also come from one of two external slow time-base tick enables.

Polarity and masking are applied after the duty comparison. A mask pins the pin at the level that is inactive for the chosen polarity. Software may restart the current period while the timer runs, but only if retriggering is enabled. The block flags an external-tick selection made while the time base is halted, and it produces no ticks while that selection is in force.

Top module: `pulse_timer`

## Requirements
- R1: After reset, with inv_pol=0, pulse_out is 0, busy is 0 and sel_err is 0.
- R2: The cycle in which start rises loads the count with period and sets busy. The count then falls by one per tick down to 0 and reloads period on the next tick, so one waveform period is period+1 ticks. The raw output is active while count > duty.
- R3: A clk_sel of 0 to 5 gives a tick once every 2^clk_sel clock cycles. The first decrement lands 2^clk_sel cycles after the start edge, and the prescaler restarts at every reload.
- R4: A clk_sel of 6 takes one tick per cycle with tb_tick_a high, and a clk_sel of 7 does the same with tb_tick_b, while tb_run is 1. The unselected tick input has no effect.
- R5: With clk_sel 6 or 7 in force and tb_run=0, sel_err is 1 and the count stays frozen. While sel_err is 1, a new clk_sel is taken up on the next clock, and counting resumes from a cleared prescaler.
- R6: When clk_sel changes while running, the old divisor stays in force until the reload that follows count 0.
- R7: With inv_pol=1, pulse_out is the complement of the raw output. With inv_pol=0, pulse_out equals the raw output.
- R8: With mask_en=1, pulse_out equals inv_pol (low for normal, high for inverted polarity), whatever the period, duty and count are.
- R9: With retrig_en=1, a sw_retrig pulse while running reloads the count with period on the next tick, which brings the output back to its active phase.
- R10: With retrig_en=0, sw_retrig has no effect on the count sequence.
- R11: When start is 0, busy is 0 from the next clock on and pulse_out rests at the inactive level (equal to inv_pol).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run control. A rising level loads the count; a low level stops the timer |
| clk_sel | input | 3 | Count clock select: 0-5 give divide by 2^code, 6 selects tick A, 7 selects tick B |
| tb_run | input | 1 | High while the external time base is running |
| tb_tick_a | input | 1 | External slow tick enable A |
| tb_tick_b | input | 1 | External slow tick enable B |
| period | input | CNT_W | Period value (reload value of the count) |
| duty | input | CNT_W | Duty compare value |
| inv_pol | input | 1 | Output polarity: 1 inverts |
| mask_en | input | 1 | Forces the output to its inactive level |
| retrig_en | input | 1 | Allows software retrigger while running |
| sw_retrig | input | 1 | Software retrigger pulse |
| pulse_out | output | 1 | Waveform output |
| busy | output | 1 | Timer running |
| sel_err | output | 1 | External tick selected while the time base is halted |

## Verification
The bench builds the block with its default 16-bit count width. It uses periods of 1 to 6, so that several full wraps fit into a few hundred cycles even at the divide-by-32 setting, and every divisor code and both external tick codes can be reached. Small periods also make the boundary-deferred clock change and the retrigger reload visible as a shift of the whole active/inactive pattern, which the bench predicts with a closed formula in elapsed cycles.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  // width of the free-running prescaler: codes 0..5 need up to 5 bits
  localparam int PS_W   = 5;
  localparam int CODE_W = 3;

  localparam logic [CODE_W-1:0] SEL_EXT_A = 3'd6;
  localparam logic [CODE_W-1:0] SEL_EXT_B = 3'd7;

  // true when the code names an external time-base tick
  function automatic logic is_ext(input logic [CODE_W-1:0] code);
    return code[2] & code[1];
  endfunction

  // internal divider tick: all prescaler bits below the code are ones
  function automatic logic div_tick(input logic [PS_W-1:0] ps,
                                    input logic [CODE_W-1:0] code);
    logic r;
    r = 1'b1;
    for (int i = 0; i < PS_W; i++) begin
      if ((i < int'(code)) && !ps[i]) r = 1'b0;
    end
    return r;
  endfunction

  // raw waveform phase from count and duty
  function automatic logic phase_active(input logic [31:0] cnt,
                                        input logic [31:0] dty);
    return cnt > dty;
  endfunction

endpackage

// File: rtl/ptm_prescale.sv
module ptm_prescale
  import ptm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  input  logic              tb_run,
  input  logic              tb_tick_a,
  input  logic              tb_tick_b,
  output logic              tick,
  output logic              err
);

  logic [PS_W-1:0] ps_q;
  logic            ext_sel;
  logic            ext_tick;
  logic            int_tick;

  assign ext_sel  = is_ext(code);
  assign err      = ext_sel && !tb_run;
  assign ext_tick = (code == SEL_EXT_B) ? tb_tick_b : tb_tick_a;
  assign int_tick = div_tick(ps_q, code);
  assign tick     = run && !err && (ext_sel ? ext_tick : int_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ps_q <= '0;
    else if (!run || clr || err)   ps_q <= '0;
    else                           ps_q <= ps_q + 1'b1;
  end

  // R3
  ps_full_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ext_sel && (ps_q == '1)) |-> tick);

  // R5
  err_cleared_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (ps_q == '0));

endmodule

// File: rtl/ptm_counter.sv
module ptm_counter
  import ptm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] sel,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  duty,
  input  logic              tick,
  input  logic              err,
  input  logic              retrig_en,
  input  logic              sw_retrig,
  output logic              run,
  output logic              start_edge,
  output logic              reload,
  output logic [CODE_W-1:0] code,
  output logic              act
);

  localparam int WIDE = 32;

  logic              run_q;
  logic              pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              retrig_ok;
  logic              wrap;

  assign run        = run_q;
  assign code       = code_q;
  assign start_edge = start && !run_q;
  assign retrig_ok  = sw_retrig && retrig_en && run_q;
  assign wrap       = tick && (cnt_q == '0);
  assign reload     = tick && (pend_q || retrig_ok || (cnt_q == '0));
  assign act        = run_q && phase_active(WIDE'(cnt_q), WIDE'(duty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      run_q <= start;
      if (start_edge) begin
        cnt_q  <= period;
        code_q <= sel;
        pend_q <= 1'b0;
      end else if (run_q) begin
        if (reload) begin
          cnt_q  <= period;
          pend_q <= 1'b0;
        end else if (tick) begin
          cnt_q  <= cnt_q - 1'b1;
        end else begin
          pend_q <= pend_q || retrig_ok;
        end
        if (wrap || err) code_q <= sel;
      end else begin
        pend_q <= 1'b0;
      end
    end
  end

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_edge |=> (run_q && (cnt_q == $past(period))));

  // R2
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start && wrap) |=> (cnt_q == $past(period)));

  // R10
  plain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && start && tick && !pend_q && !retrig_en && (cnt_q != '0))
      |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R5
  frozen_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && run_q && start) |=> $stable(cnt_q));

endmodule

// File: rtl/ptm_outstage.sv
module ptm_outstage (
  input  logic act,
  input  logic inv_pol,
  input  logic mask_en,
  output logic pulse_out
);

  logic polar;

  // polarity first, mask last
  assign polar     = act ^ inv_pol;
  assign pulse_out = mask_en ? inv_pol : polar;

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
  import ptm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] clk_sel,
  input  logic              tb_run,
  input  logic              tb_tick_a,
  input  logic              tb_tick_b,
  input  logic [CNT_W-1:0]  period,
  input  logic [CNT_W-1:0]  duty,
  input  logic              inv_pol,
  input  logic              mask_en,
  input  logic              retrig_en,
  input  logic              sw_retrig,
  output logic              pulse_out,
  output logic              busy,
  output logic              sel_err
);

  logic              run_w;
  logic              start_edge_w;
  logic              reload_w;
  logic              tick_w;
  logic              err_w;
  logic              act_w;
  logic [CODE_W-1:0] code_w;

  ptm_prescale u_ps (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_w),
    .clr       (start_edge_w || reload_w),
    .code      (code_w),
    .tb_run    (tb_run),
    .tb_tick_a (tb_tick_a),
    .tb_tick_b (tb_tick_b),
    .tick      (tick_w),
    .err       (err_w)
  );

  ptm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .sel        (clk_sel),
    .period     (period),
    .duty       (duty),
    .tick       (tick_w),
    .err        (err_w),
    .retrig_en  (retrig_en),
    .sw_retrig  (sw_retrig),
    .run        (run_w),
    .start_edge (start_edge_w),
    .reload     (reload_w),
    .code       (code_w),
    .act        (act_w)
  );

  ptm_outstage u_out (
    .act       (act_w),
    .inv_pol   (inv_pol),
    .mask_en   (mask_en),
    .pulse_out (pulse_out)
  );

  assign busy    = run_w;
  assign sel_err = err_w;

  // R11
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pulse_out == inv_pol));

  // R5
  no_tick_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |-> !reload_w);

endmodule

// File: tb/pulse_timer_tb_top.sv
`timescale 1ns/1ps
module pulse_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  clk_sel = 3'd0;
  logic        tb_run = 1'b1;
  logic        tb_tick_a = 1'b0;
  logic        tb_tick_b = 1'b0;
  logic [15:0] period = 16'd0;
  logic [15:0] duty = 16'd0;
  logic        inv_pol = 1'b0;
  logic        mask_en = 1'b0;
  logic        retrig_en = 1'b0;
  logic        sw_retrig = 1'b0;
  logic        pulse_out;
  logic        busy;
  logic        sel_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_timer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_sel(clk_sel),
    .tb_run(tb_run), .tb_tick_a(tb_tick_a), .tb_tick_b(tb_tick_b),
    .period(period), .duty(duty), .inv_pol(inv_pol), .mask_en(mask_en),
    .retrig_en(retrig_en), .sw_retrig(sw_retrig),
    .pulse_out(pulse_out), .busy(busy), .sel_err(sel_err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected pin level n cycles after a (re)load, divisor 2^k
  function automatic int exp_pin(int n, int p, int d, int k);
    int cnt;
    int a;
    cnt = p - ((n >> k) % (p + 1));
    a = (cnt > d) ? 1 : 0;
    if (mask_en) return int'(inv_pol);
    return a ^ int'(inv_pol);
  endfunction

  // sample n0..n1-1; caller sits at the negedge of sample n0
  task automatic span(input string req, int p, int d, int k, int n0, int n1);
    for (int n = n0; n < n1; n++) begin
      check(req, int'(pulse_out), exp_pin(n, p, d, k));
      @(negedge clk);
    end
  endtask

  task automatic go(int p, int d, int k);
    period = 16'(p); duty = 16'(d); clk_sel = 3'(k);
    start = 1'b1;
    @(negedge clk);
  endtask

  task automatic halt();
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 pulse_out", int'(pulse_out), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 sel_err", int'(sel_err), 0);
  endtask

  task automatic t_basic();
    go(4, 1, 0);
    check("R2 busy", int'(busy), 1);
    span("R2", 4, 1, 0, 0, 16);
    halt();
  endtask

  task automatic t_divs();
    go(2, 0, 3);  span("R3 div8", 2, 0, 3, 0, 50);  halt();
    go(1, 0, 5);  span("R3 div32", 1, 0, 5, 0, 130); halt();
    go(3, 1, 1);  span("R3 div2", 3, 1, 1, 0, 20);  halt();
  endtask

  task automatic t_pol_mask();
    inv_pol = 1'b1;
    go(3, 1, 2); span("R7", 3, 1, 2, 0, 34); halt();
    mask_en = 1'b1;
    go(3, 1, 0); span("R8 inv", 3, 1, 0, 0, 10); halt();
    inv_pol = 1'b0;
    go(3, 1, 0); span("R8 norm", 3, 1, 0, 0, 10); halt();
    mask_en = 1'b0;
  endtask

  task automatic t_stop();
    go(5, 0, 0);
    span("R11 pre", 5, 0, 0, 0, 3);
    start = 1'b0;
    @(negedge clk);
    check("R11 busy", int'(busy), 0);
    check("R11 level", int'(pulse_out), 0);
    inv_pol = 1'b1;
    @(negedge clk);
    check("R11 inv level", int'(pulse_out), 1);
    inv_pol = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_retrig();
    retrig_en = 1'b1;
    go(6, 2, 0);
    span("R9 pre", 6, 2, 0, 0, 5);
    check("R9 low before", int'(pulse_out), 0);  // n=5, count 1
    sw_retrig = 1'b1;
    @(negedge clk);
    sw_retrig = 1'b0;
    span("R9 reload", 6, 2, 0, 0, 9);
    halt();
    retrig_en = 1'b0;
    go(6, 2, 0);
    span("R10 pre", 6, 2, 0, 0, 5);
    check("R10 n5", int'(pulse_out), exp_pin(5, 6, 2, 0));
    sw_retrig = 1'b1;
    @(negedge clk);
    sw_retrig = 1'b0;
    span("R10 ignored", 6, 2, 0, 6, 16);
    halt();
  endtask

  task automatic pulse_a();
    tb_tick_a = 1'b1; @(negedge clk); tb_tick_a = 1'b0;
  endtask
  task automatic pulse_b();
    tb_tick_b = 1'b1; @(negedge clk); tb_tick_b = 1'b0;
  endtask

  task automatic t_ext();
    tb_run = 1'b1;
    go(2, 0, 6);
    check("R4 A cnt2", int'(pulse_out), 1);
    @(negedge clk);
    check("R4 A idle", int'(pulse_out), 1);
    pulse_a(); check("R4 A cnt1", int'(pulse_out), 1);
    pulse_b(); check("R4 B ignored", int'(pulse_out), 1);
    pulse_a(); check("R4 A cnt0", int'(pulse_out), 0);
    pulse_a(); check("R4 A wrap", int'(pulse_out), 1);
    halt();
    go(2, 1, 7);
    pulse_a(); check("R4 A ignored", int'(pulse_out), 1);
    pulse_b(); check("R4 B cnt1", int'(pulse_out), 0);
    halt();
  endtask

  task automatic t_err();
    tb_run = 1'b0;
    go(3, 2, 6);
    check("R5 flag", int'(sel_err), 1);
    for (int i = 0; i < 4; i++) begin
      pulse_a();
      check("R5 frozen", int'(pulse_out), 1);
    end
    clk_sel = 3'd1;
    @(negedge clk);
    check("R5 flag clear", int'(sel_err), 0);
    span("R5 resume", 3, 2, 1, 0, 12);
    halt();
    tb_run = 1'b1;
  endtask

  task automatic t_switch();
    go(3, 2, 0);
    span("R6 old", 3, 2, 0, 0, 1);
    clk_sel = 3'd1;
    for (int n = 1; n < 4; n++) begin
      check("R6 old div", int'(pulse_out), exp_pin(n, 3, 2, 0));
      @(negedge clk);
    end
    span("R6 new div", 3, 2, 1, 0, 16);
    halt();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_divs();
    t_pol_mask();
    t_stop();
    t_retrig();
    t_ext();
    t_err();
    t_switch();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule